// File: doc/BRIEF.md
# Burst Fragmenter with Read Bypass Buffer

This block sits between a stream of decoded memory requests and the DRAM command path. Each accepted request, given as a byte address and a byte count, is cut into bursts of `WORD_BYTES * BURST_LEN` bytes. The bursts go out one by one on a valid/ready stream, at ascending burst-aligned addresses. The block then counts the data beats returning from the memory for reads, or the write-complete pulses for writes. It raises a bus response either at the first beat or at the last beat of the final burst, as a control pin selects.

A small read that was fetched from DRAM leaves its whole burst in a local buffer. The buffer is tagged with the burst-aligned address, which covers rank, bank, row and column base, and with a mask of the bytes already handed out. A later small read that falls inside the same burst and touches none of those bytes is served from the buffer. It issues no DRAM command and gets its response in the cycle after acceptance. Any other request empties the buffer: a write, or a read that misses.

Back-pressure: `req_ready` is high only when no request is in flight, and a request transfers on a cycle where `req_valid` and `req_ready` are both high. On the burst stream, `brs_valid` and the burst fields hold steady until a cycle with `brs_ready` high. Responses carry no back-pressure and are single-cycle pulses.

Top module: `burst_frag_bypass`

## Requirements
- R1: The burst size BB is `WORD_BYTES * BURST_LEN` bytes (16 by default), and every burst address has its low log2(BB) bits at zero.
- R2: A request of n bytes at address a issues exactly ceil(((a mod BB) + n) / BB) bursts. They start at floor(a/BB)*BB, rise by BB each, and carry the request's write flag on `brs_write`.
- R3: `brs_last` is 1 on the final burst of a request and 0 on every other burst.
- R4: For a read, with `early_resp` = 1 the response pulse comes one cycle after the first beat of the final burst. With `early_resp` = 0 it comes one cycle after that burst's last (BURST_LEN-th) beat. `rsp_write` is 0 on a read response.
- R5: For a write, the response pulse with `rsp_write` = 1 comes one cycle after the `mem_wr_done` pulse of the final burst, and not after earlier ones.
- R6: A read with n < BB that fits inside one burst and is fetched from DRAM fills the buffer. The tag is that burst's address and the consumed mask is the read's bytes.
- R7: A read hits the buffer when four things hold: n < BB, its burst address equals the tag, its bytes lie within that burst, and none of them is in the consumed mask. A hit issues no burst, raises `rsp_valid` with `rsp_bypass` = 1 one cycle after acceptance, and adds its bytes to the consumed mask.
- R8: A read that overlaps the consumed bytes or targets another burst misses and goes to DRAM.
- R9: Any accepted write empties the buffer, so a following read to the buffered burst goes to DRAM.
- R10: A read of n >= BB is never served from the buffer and leaves the buffer empty.
- R11: `req_ready` is low from acceptance until the request's final beat or write-complete pulse. While `brs_valid` is high and `brs_ready` low, the burst fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_resp | input | 1 | 1: read response at first beat; 0: at last beat |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | LEN_W | Byte count, at least 1 |
| brs_valid | output | 1 | Burst command valid |
| brs_ready | input | 1 | Burst command accepted |
| brs_write | output | 1 | Burst is a write |
| brs_addr | output | ADDR_W | Burst-aligned byte address |
| brs_last | output | 1 | Final burst of the request |
| mem_rd_beat | input | 1 | One read data word returned |
| mem_wr_done | input | 1 | One write burst fully written |
| rsp_valid | output | 1 | Response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_bypass | output | 1 | Response served from the buffer |

## Verification
The assertions assume a well-behaved memory side. Read beats and write-complete pulses arrive only for bursts already issued, and only of the kind matching the request in flight. Every request carries at least one byte, and `early_resp` is held while a request is in flight. The stimulus respects this: it hands over every burst of a request before it returns any data, then sends exactly BURST_LEN beats per burst for reads or one pulse per burst for writes. It only presents a new request once `req_ready` is high again. Offsets and lengths are swept across the whole burst, and follow-up reads land just after, inside, or across the previously consumed bytes.

// File: rtl/bfrag_pkg.sv
package bfrag_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BYP, ST_BUSY} ctl_st_e;
endpackage

// File: rtl/bfrag_split.sv
module bfrag_split #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int NB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [NB_W-1:0]   load_nb,
  input  logic              load_wr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_last,
  output logic              out_wr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFF_W;

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NB_W-1:0]   left_q;
  logic              wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      wr_q     <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      addr_q   <= load_base;
      left_q   <= load_nb;
      wr_q     <= load_wr;
    end else if (active_q && out_ready) begin
      if (left_q == NB_W'(1)) active_q <= 1'b0;
      left_q <= left_q - NB_W'(1);
      addr_q <= addr_q + STEP;
    end
  end

  assign out_valid = active_q;
  assign out_addr  = addr_q;
  assign out_last  = active_q && (left_q == NB_W'(1));
  assign out_wr    = wr_q;

  // R1
  brs_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[OFF_W-1:0] == '0));

  // R11
  brs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last)));
endmodule

// File: rtl/bfrag_track.sv
module bfrag_track #(
  parameter int NB_W      = 6,
  parameter int BURST_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NB_W-1:0] start_nb,
  input  logic            start_wr,
  input  logic            start_early,
  input  logic            beat,
  input  logic            wr_done,
  output logic            rsp,
  output logic            rsp_wr,
  output logic            done
);
  localparam int WC_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [WC_W-1:0] WC_END = WC_W'(BURST_LEN - 1);

  logic            busy_q, wr_q, early_q, rsp_q, rspwr_q;
  logic [NB_W-1:0] nb_q, rb_q;
  logic [WC_W-1:0] wcnt_q;
  logic            last_bur, rd_fire, wr_fire, rd_beat;

  assign last_bur = (rb_q == nb_q - NB_W'(1));
  assign rd_beat  = busy_q && !wr_q && beat;
  assign rd_fire  = rd_beat && last_bur && (early_q ? (wcnt_q == '0) : (wcnt_q == WC_END));
  assign wr_fire  = busy_q && wr_q && wr_done && last_bur;
  assign done     = busy_q && last_bur && (wr_q ? wr_done : (beat && wcnt_q == WC_END));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      early_q <= 1'b0;
      nb_q    <= '0;
      rb_q    <= '0;
      wcnt_q  <= '0;
      rsp_q   <= 1'b0;
      rspwr_q <= 1'b0;
    end else begin
      rsp_q   <= rd_fire || wr_fire;
      rspwr_q <= wr_fire;
      if (start) begin
        busy_q  <= 1'b1;
        wr_q    <= start_wr;
        early_q <= start_early;
        nb_q    <= start_nb;
        rb_q    <= '0;
        wcnt_q  <= '0;
      end else begin
        if (done) busy_q <= 1'b0;
        if (rd_beat) begin
          if (wcnt_q == WC_END) begin
            wcnt_q <= '0;
            rb_q   <= rb_q + NB_W'(1);
          end else begin
            wcnt_q <= wcnt_q + WC_W'(1);
          end
        end
        if (busy_q && wr_q && wr_done) rb_q <= rb_q + NB_W'(1);
      end
    end
  end

  assign rsp    = rsp_q;
  assign rsp_wr = rspwr_q;

  // R5
  wr_rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp && rsp_wr) |-> $past(wr_done));

  // R4
  rd_rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp && !rsp_wr) |-> $past(beat));
endmodule

// File: rtl/bfrag_buf.sv
module bfrag_buf #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [LEN_W-1:0]  lk_bytes,
  input  logic              consume,
  input  logic              kill,
  input  logic              fill,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LEN_W-1:0]  fill_bytes,
  output logic              hit
);
  localparam int BB    = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - OFF_W;

  function automatic logic [BB-1:0] span_mask(input logic [OFF_W-1:0] off,
                                               input logic [LEN_W-1:0] n);
    logic [BB-1:0] m;
    for (int i = 0; i < BB; i++)
      m[i] = (i >= int'(off)) && (i < int'(off) + int'(n));
    return m;
  endfunction

  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic [BB-1:0]    used_q;
  logic [BB-1:0]    lk_mask;
  logic [LEN_W+1:0] lk_end;

  assign lk_mask = span_mask(lk_addr[OFF_W-1:0], lk_bytes);
  assign lk_end  = (LEN_W+2)'(lk_addr[OFF_W-1:0]) + (LEN_W+2)'(lk_bytes);
  assign hit = vld_q && (tag_q == lk_addr[ADDR_W-1:OFF_W]) && (lk_bytes != '0)
            && ((LEN_W+2)'(lk_bytes) < (LEN_W+2)'(BB)) && (lk_end <= (LEN_W+2)'(BB))
            && ((lk_mask & used_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      used_q <= '0;
    end else if (kill) begin
      vld_q  <= 1'b0;
    end else if (fill) begin
      vld_q  <= 1'b1;
      tag_q  <= fill_addr[ADDR_W-1:OFF_W];
      used_q <= span_mask(fill_addr[OFF_W-1:0], fill_bytes);
    end else if (consume) begin
      used_q <= used_q | lk_mask;
    end
  end
endmodule

// File: rtl/burst_frag_bypass.sv
module burst_frag_bypass
  import bfrag_pkg::*;
#(
  parameter int WORD_BYTES = 2,
  parameter int BURST_LEN  = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_resp,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_bytes,
  output logic              brs_valid,
  input  logic              brs_ready,
  output logic              brs_write,
  output logic [ADDR_W-1:0] brs_addr,
  output logic              brs_last,
  input  logic              mem_rd_beat,
  input  logic              mem_wr_done,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_bypass
);
  localparam int BB    = WORD_BYTES * BURST_LEN;
  localparam int OFF_W = $clog2(BB);
  localparam int NB_W  = LEN_W - OFF_W + 2;
  localparam int SP_W  = LEN_W + 2;

  ctl_st_e st_q;
  logic              accept, hit, hit_now, start;
  logic [SP_W-1:0]   span;
  logic [NB_W-1:0]   nb;
  logic [ADDR_W-1:0] base;
  logic              fill_cand;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  bytes_q;
  logic              fill_q, wr_req_q;
  logic              trk_rsp, trk_rsp_wr, trk_done;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_now   = !req_write && hit;
  assign start     = accept && !hit_now;
  assign span      = SP_W'(req_addr[OFF_W-1:0]) + SP_W'(req_bytes) + SP_W'(BB - 1);
  assign nb        = NB_W'(span >> OFF_W);
  assign base      = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign fill_cand = !req_write && (nb == NB_W'(1)) && (SP_W'(req_bytes) < SP_W'(BB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      bytes_q  <= '0;
      fill_q   <= 1'b0;
      wr_req_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) st_q <= hit_now ? ST_BYP : ST_BUSY;
        ST_BYP:  st_q <= ST_IDLE;
        ST_BUSY: if (trk_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (start) begin
        addr_q   <= req_addr;
        bytes_q  <= req_bytes;
        fill_q   <= fill_cand;
        wr_req_q <= req_write;
      end
    end
  end

  bfrag_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB_W(NB_W)) u_split (
    .clk(clk), .rst_n(rst_n), .load(start), .load_base(base), .load_nb(nb),
    .load_wr(req_write), .out_ready(brs_ready), .out_valid(brs_valid),
    .out_addr(brs_addr), .out_last(brs_last), .out_wr(brs_write)
  );

  bfrag_track #(.NB_W(NB_W), .BURST_LEN(BURST_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .start_nb(nb), .start_wr(req_write),
    .start_early(early_resp), .beat(mem_rd_beat), .wr_done(mem_wr_done),
    .rsp(trk_rsp), .rsp_wr(trk_rsp_wr), .done(trk_done)
  );

  bfrag_buf #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .lk_addr(req_addr), .lk_bytes(req_bytes),
    .consume(accept && hit_now),
    .kill(start || (trk_done && wr_req_q)),
    .fill(trk_done && fill_q), .fill_addr(addr_q), .fill_bytes(bytes_q),
    .hit(hit)
  );

  assign rsp_bypass = (st_q == ST_BYP);
  assign rsp_valid  = trk_rsp || rsp_bypass;
  assign rsp_write  = trk_rsp && trk_rsp_wr;

  // R7
  byp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BYP) |-> !brs_valid);

  // R7
  byp_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bypass |-> $past(req_valid && req_ready && !req_write));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brs_valid |-> !req_ready);
endmodule

// File: tb/sim_burst_frag_bypass.sv
module sim_burst_frag_bypass;
  localparam int BB = 16;
  localparam int BL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early_resp = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_bytes = '0;
  logic brs_ready = 1'b0, mem_rd_beat = 1'b0, mem_wr_done = 1'b0;
  logic req_ready, brs_valid, brs_write, brs_last, rsp_valid, rsp_write, rsp_bypass;
  logic [15:0] brs_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit mv = 0;
  int mtag = 0;
  logic [BB-1:0] mm = '0;

  always #4 clk = ~clk;

  burst_frag_bypass #(.WORD_BYTES(2), .BURST_LEN(BL), .ADDR_W(16), .LEN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .early_resp(early_resp), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_bytes(req_bytes), .brs_valid(brs_valid), .brs_ready(brs_ready),
    .brs_write(brs_write), .brs_addr(brs_addr), .brs_last(brs_last),
    .mem_rd_beat(mem_rd_beat), .mem_wr_done(mem_wr_done), .rsp_valid(rsp_valid),
    .rsp_write(rsp_write), .rsp_bypass(rsp_bypass)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  task automatic run_req(input bit wr, input int addr, input int n, input bit early,
                         input string dtag);
    int off, nb, got, guard;
    bit exp_hit;
    logic [BB-1:0] m;
    off = addr % BB;
    nb = (off + n + BB - 1) / BB;
    m = '0;
    for (int i = 0; i < BB; i++) if (i >= off && i < off + n) m[i] = 1'b1;
    exp_hit = !wr && mv && (mtag == addr / BB) && (n < BB) && (off + n <= BB) && ((m & mm) == '0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
    early_resp = early; req_valid = 1'b1; req_write = wr;
    req_addr = 16'(addr); req_bytes = 8'(n);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_bypass == exp_hit, dtag, int'(rsp_bypass), int'(exp_hit));
    if (exp_hit) begin
      chk(rsp_valid && !brs_valid, "R7 bypass response, no burst", int'(rsp_valid), 1);
      mm = mm | m;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 single pulse", int'(rsp_valid), 0);
      return;
    end
    chk(rsp_valid == 1'b0, "R7 no early response on miss", int'(rsp_valid), 0);
    mv = 0;
    got = 0; guard = 0;
    while (got < nb && guard < 200) begin
      chk(req_ready == 1'b0, "R11 busy blocks requests", int'(req_ready), 0);
      brs_ready = (guard % 3 != 1);
      if (brs_valid && brs_ready) begin
        chk(int'(brs_addr) == (addr - off) + got * BB, "R2 burst address", int'(brs_addr), (addr - off) + got * BB);
        chk(brs_addr % BB == 0, "R1 burst alignment", int'(brs_addr), 0);
        chk(brs_last == (got == nb - 1), "R3 last flag", int'(brs_last), int'(got == nb - 1));
        chk(brs_write == wr, "R2 write flag", int'(brs_write), int'(wr));
        got++;
      end
      guard++;
      @(negedge clk);
    end
    brs_ready = 1'b0;
    chk(brs_valid == 1'b0, "R2 burst count", int'(brs_valid), 0);
    if (wr) begin
      for (int b = 0; b < nb; b++) begin
        mem_wr_done = 1'b1;
        @(negedge clk);
        mem_wr_done = 1'b0;
        chk(rsp_valid == (b == nb - 1), "R5 write response timing", int'(rsp_valid), int'(b == nb - 1));
        if (b == nb - 1) chk(rsp_write && !rsp_bypass, "R5 write response kind", int'(rsp_write), 1);
      end
    end else begin
      for (int b = 0; b < nb; b++) begin
        for (int k = 0; k < BL; k++) begin
          bit e;
          mem_rd_beat = 1'b1;
          @(negedge clk);
          e = (b == nb - 1) && (early ? (k == 0) : (k == BL - 1));
          chk(rsp_valid == e, "R4 read response timing", int'(rsp_valid), int'(e));
          if (e) chk(!rsp_write && !rsp_bypass, "R4 read response kind", int'(rsp_write), 0);
        end
      end
      mem_rd_beat = 1'b0;
    end
    chk(req_ready == 1'b1, "R11 ready after completion", int'(req_ready), 1);
    if (!wr && nb == 1 && n < BB) begin
      mv = 1; mtag = addr / BB; mm = m;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    chk(brs_valid == 1'b0, "R2 reset no burst", int'(brs_valid), 0);
    chk(rsp_valid == 1'b0, "R4 reset no response", int'(rsp_valid), 0);

    // R6 / R7: fill, then disjoint hits
    run_req(0, 16'h0100, 4, 0, "R6 first small read misses");
    run_req(0, 16'h0104, 4, 1, "R6 R7 disjoint read hits");
    run_req(0, 16'h0108, 8, 0, "R7 tail read hits");
    // R8: overlap and different burst
    run_req(0, 16'h0102, 2, 0, "R8 overlapping read misses");
    run_req(0, 16'h0110, 2, 0, "R8 other burst misses");
    run_req(0, 16'h0112, 2, 1, "R7 hit after refill");
    // R9: write empties buffer
    run_req(1, 16'h0300, 2, 0, "R9 write goes to memory");
    run_req(0, 16'h0114, 2, 0, "R9 read after write misses");
    // R10: full-burst reads neither hit nor fill
    run_req(0, 16'h0400, 16, 0, "R10 full burst read misses");
    run_req(0, 16'h0404, 4, 0, "R10 no fill from full burst");
    run_req(0, 16'h0500, 33, 1, "R10 multi burst read");

    // Sweep offsets and lengths with a follow-up read right after each
    for (int off = 0; off < BB; off++) begin
      for (int s = 0; s < 6; s++) begin
        int n, a2;
        n = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 8 : (s == 3) ? 15 : (s == 4) ? 16 : 21;
        run_req(0, 16'h1000 + off, n, n[0], "R7 sweep primary");
        a2 = 16'h1000 + ((off + n) % BB);
        run_req(0, a2, 2, off[0], "R7 sweep follow-up");
      end
    end
    for (int off = 0; off < BB; off += 5) begin
      run_req(1, 16'h2000 + off, 1, 0, "R5 sweep write");
      run_req(1, 16'h2000 + off, 31, 0, "R5 sweep long write");
    end
    summary();
  end
endmodule